// File: doc/BRIEF.md
# Dual-Domain Programmable Reset Sequencer

This block produces the active-low system reset for a chip with two power domains. An always-on standby domain has its own active-low reset input, and so does a switchable working domain. While either input is low the system reset is held low. Once both inputs are high, a down-counter on the 32.768 kHz slow clock counts out a programmable hold-off. When that count expires, an expiry flag is passed into the bus-clock domain, and the system reset is released on a rising edge of the bus clock.

The hold-off length is held in a 20-bit register in the bus-clock domain. Only the standby reset restores that register to its default of 262 slow-clock cycles, which is about 8 ms. Software can write a new value through a one-cycle write strobe and then pulse the working reset. The next release then uses the new length, because the working reset does not disturb the register. A working-state output mirrors the released state so that off-chip power can follow it.

Top module: `reset_sequencer`

## Requirements
- R1: `sys_rst_n` is active low, and its low-to-high transition happens only at a rising edge of `bus_clk`.
- R2: Driving either `stand_rst_n` or `work_rst_n` low forces `sys_rst_n` low at once, with no clock edge needed.
- R3: For a programmed delay N, `sys_rst_n` rises no earlier than (N+2) and no later than (N+4) `slow_clk` periods after the later of the two reset inputs returns high.
- R4: The delay register is 20 bits wide and holds 262 after a standby reset.
- R5: When `cfg_wr_en` is high at a rising edge of `bus_clk`, `cfg_wr_data` is stored, and the next reset sequence uses it as N.
- R6: A working reset leaves the stored delay unchanged. Only a standby reset restores the default.
- R7: If a reset input goes low while the hold-off is still counting, the count starts again from the full programmed value once the inputs are high again.
- R8: A programmed delay of zero releases `sys_rst_n` within the R3 window for N = 0.
- R9: `working` is high exactly when `sys_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; the release edge and the write port use it |
| slow_clk | input | 1 | 32.768 kHz clock that drives the hold-off counter |
| stand_rst_n | input | 1 | Standby-domain reset, active low |
| work_rst_n | input | 1 | Working-domain reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the delay register |
| cfg_wr_data | input | 20 | New hold-off length in slow-clock cycles |
| sys_rst_n | output | 1 | System reset, active low |
| working | output | 1 | High while the system is out of reset |

## Verification
Two functions can meet in the same slow-clock window: loading the counter from the delay register, and the counter's expiry. With a zero delay the load is followed at once by expiry on the first slow edge after the synchronized release. That case is provoked by writing zero and pulsing the working reset. It is judged by the release landing in the N = 0 window and on a bus-clock rising edge. A second collision is a reset input dropping mid-count while the expiry path is armed. The bench checks that the output falls within a nanosecond and that the next release is measured from the second deassertion using the full programmed length.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing constants for the reset sequencer.
// Assumes a 32.768 kHz slow clock; the default is about 8 ms of it.
package rs_pkg;
    localparam int unsigned RS_DELAY_W       = 20;
    localparam int unsigned RS_DEFAULT_DELAY = 262;
    localparam int unsigned RS_SYNC_STAGES   = 2;
endpackage

// File: rtl/rs_reset_sync.sv
`timescale 1ns/1ps
// Module: reset synchronizer. Asserts asynchronously and releases after
// STAGES rising edges of clk. Assumes STAGES >= 2.
module rs_reset_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in after release; clear the whole chain on assertion.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/rs_delay_reg.sv
`timescale 1ns/1ps
// Module: hold-off length register in the bus-clock domain.
// Only the synchronized standby reset loads the default. The working reset
// never reaches this register, so a value written here survives it.
module rs_delay_reg #(
    parameter int unsigned W   = 20,
    parameter int unsigned DEF = 262
) (
    input  logic         clk,
    input  logic         stand_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] delay
);
    localparam logic [W-1:0] DEF_V = W'(DEF);

    // Synchronous active-low reset to default; otherwise take writes.
    always_ff @(posedge clk) begin
        if (!stand_n)   delay <= DEF_V;
        else if (wr_en) delay <= wr_data;
    end

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!stand_n)
        wr_en |=> delay == $past(wr_data)); // R5
    AST_KEEP_VALUE: assert property (@(posedge clk) disable iff (!stand_n)
        !wr_en |=> $stable(delay)); // R6
endmodule

// File: rtl/rs_holdoff_counter.sv
`timescale 1ns/1ps
// Module: slow-clock hold-off counter. While the internal reset is active
// it reloads the programmed length. After that it counts down to zero, and
// on the next edge it raises done. done is cleared asynchronously, so a
// stale flag never survives a fresh reset. The delay input is assumed to
// be quasi-static: software writes it while the system is running.
module rs_holdoff_counter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         int_rst_n,
    input  logic [W-1:0] delay_in,
    output logic         done
);
    logic [W-1:0] cnt;

    // Reload during reset, then step down toward zero.
    always_ff @(posedge clk) begin
        if (!int_rst_n)   cnt <= delay_in;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    // Expiry flag: raised one edge after the count reaches zero, then held.
    always_ff @(posedge clk or negedge int_rst_n) begin
        if (!int_rst_n)     done <= 1'b0;
        else if (cnt == '0) done <= 1'b1;
    end

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!int_rst_n)
        (cnt != '0 && !done) |=> cnt == $past(cnt) - 1'b1); // R3
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!int_rst_n)
        done |=> done); // R3
endmodule

// File: rtl/rs_release.sv
`timescale 1ns/1ps
// Module: brings the expiry flag into the bus-clock domain and releases
// the system reset on the first bus edge after the synchronized flag is
// high. Any raw reset input clears every stage here asynchronously.
module rs_release #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic done_in,
    output logic rst_out_n
);
    logic [STAGES-1:0] flag_chain;
    logic              flag_s;

    // Two-flop (or longer) synchronizer for the slow-domain flag.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) flag_chain <= '0;
        else         flag_chain <= {flag_chain[STAGES-2:0], done_in};
    end

    assign flag_s = flag_chain[STAGES-1];

    // Output reset: low on assertion, set on a bus edge once the flag is seen.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     rst_out_n <= 1'b0;
        else if (flag_s) rst_out_n <= 1'b1;
    end

    AST_RELEASE_ON_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_out_n) |-> $past(flag_s)); // R1
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
// Module: top of the dual-domain reset sequencer. It combines the two raw
// resets, synchronizes them into each clock domain, holds the hold-off
// length, counts it out on the slow clock, and releases the system reset
// on the bus clock. Assumes both clocks run freely while the resets move.
module reset_sequencer #(
    parameter int unsigned DELAY_W       = rs_pkg::RS_DELAY_W,
    parameter int unsigned DEFAULT_DELAY = rs_pkg::RS_DEFAULT_DELAY,
    parameter int unsigned SYNC_STAGES   = rs_pkg::RS_SYNC_STAGES
) (
    input  logic               bus_clk,
    input  logic               slow_clk,
    input  logic               stand_rst_n,
    input  logic               work_rst_n,
    input  logic               cfg_wr_en,
    input  logic [DELAY_W-1:0] cfg_wr_data,
    output logic               sys_rst_n,
    output logic               working
);
    logic               any_rst_n;
    logic               stand_bus_n;
    logic               stand_slow_n;
    logic               work_slow_n;
    logic               int_rst_n;
    logic [DELAY_W-1:0] delay_val;
    logic               expired;

    assign any_rst_n = stand_rst_n & work_rst_n;

    rs_reset_sync #(.STAGES(SYNC_STAGES)) u_stand_bus (
        .clk(bus_clk), .arst_n(stand_rst_n), .srst_n(stand_bus_n));

    rs_reset_sync #(.STAGES(SYNC_STAGES)) u_stand_slow (
        .clk(slow_clk), .arst_n(stand_rst_n), .srst_n(stand_slow_n));

    rs_reset_sync #(.STAGES(SYNC_STAGES)) u_work_slow (
        .clk(slow_clk), .arst_n(work_rst_n), .srst_n(work_slow_n));

    assign int_rst_n = stand_slow_n & work_slow_n;

    rs_delay_reg #(.W(DELAY_W), .DEF(DEFAULT_DELAY)) u_delay (
        .clk(bus_clk), .stand_n(stand_bus_n), .wr_en(cfg_wr_en),
        .wr_data(cfg_wr_data), .delay(delay_val));

    rs_holdoff_counter #(.W(DELAY_W)) u_count (
        .clk(slow_clk), .int_rst_n(int_rst_n), .delay_in(delay_val),
        .done(expired));

    rs_release #(.STAGES(SYNC_STAGES)) u_release (
        .clk(bus_clk), .arst_n(any_rst_n), .done_in(expired),
        .rst_out_n(sys_rst_n));

    assign working = sys_rst_n;
endmodule

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
    localparam real TBUS  = 4.0;
    localparam real TSLOW = 32.0;

    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        stand_rst_n = 1'b0;
    logic        work_rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [19:0] cfg_wr_data = '0;
    logic        sys_rst_n;
    logic        working;

    int   total = 0;
    int   bad = 0;
    real  rise_t = 0.0;
    logic rise_clk = 1'b0;

    reset_sequencer dut (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .stand_rst_n(stand_rst_n),
        .work_rst_n(work_rst_n), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .sys_rst_n(sys_rst_n), .working(working));

    always #(TBUS/2) bus_clk = ~bus_clk;
    initial begin
        #1;
        forever #(TSLOW/2) slow_clk = ~slow_clk;
    end

    always @(posedge sys_rst_n) begin
        rise_t   = $realtime;
        rise_clk = bus_clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_delay(input logic [19:0] v);
        @(negedge bus_clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge bus_clk);
        cfg_wr_en = 1'b0;
    endtask

    // Wait for release after t0 and judge the window for delay n.
    task automatic measure(input real t0, input int n, input string req);
        int  waited = 0;
        real el, lo, hi;
        while (sys_rst_n !== 1'b1 && waited < (n + 10) * 32) begin
            #1; waited++;
        end
        el = rise_t - t0;
        lo = (n + 2) * TSLOW;
        hi = (n + 4) * TSLOW;
        chk(sys_rst_n === 1'b1 && el >= lo && el <= hi, req,
            "release delay ns", longint'(el), longint'(lo));
        chk(rise_clk === 1'b1, "R1", "release on bus rising edge",
            longint'(rise_clk), 1);
        #0.5;
        chk(working === sys_rst_n, "R9", "working mirrors reset",
            longint'(working), longint'(sys_rst_n));
    endtask

    task automatic pulse_work_and_measure(input int n, input string req);
        real t0;
        #7; work_rst_n = 1'b0;
        #1;
        chk(sys_rst_n === 1'b0, "R2", "work reset forces output low",
            longint'(sys_rst_n), 0);
        #100; work_rst_n = 1'b1; t0 = $realtime;
        measure(t0, n, req);
    endtask

    task automatic t_reset_state();
        #200;
        chk(sys_rst_n === 1'b0, "R2", "held low under both resets",
            longint'(sys_rst_n), 0);
        chk(working === 1'b0, "R9", "working low in reset",
            longint'(working), 0);
    endtask

    task automatic t_default();
        real t0;
        stand_rst_n = 1'b1; work_rst_n = 1'b1; t0 = $realtime;
        measure(t0, 262, "R4");
    endtask

    task automatic t_write_keep();
        write_delay(20'd40);
        #20;
        chk(sys_rst_n === 1'b1, "R5", "write leaves output released",
            longint'(sys_rst_n), 1);
        pulse_work_and_measure(40, "R6");
        pulse_work_and_measure(40, "R5");
    endtask

    task automatic t_restart();
        real t0;
        #5; work_rst_n = 1'b0; #100; work_rst_n = 1'b1;
        #(20 * TSLOW);
        chk(sys_rst_n === 1'b0, "R7", "still counting mid hold-off",
            longint'(sys_rst_n), 0);
        work_rst_n = 1'b0;
        #1;
        chk(sys_rst_n === 1'b0, "R2", "mid-count reassertion low",
            longint'(sys_rst_n), 0);
        #50; work_rst_n = 1'b1; t0 = $realtime;
        measure(t0, 40, "R7");
    endtask

    task automatic t_zero();
        write_delay(20'd0);
        pulse_work_and_measure(0, "R8");
    endtask

    task automatic t_standby();
        real t0;
        write_delay(20'd100);
        #3; stand_rst_n = 1'b0;
        #1;
        chk(sys_rst_n === 1'b0, "R2", "standby reset forces output low",
            longint'(sys_rst_n), 0);
        #200; stand_rst_n = 1'b1; t0 = $realtime;
        measure(t0, 262, "R6");
    endtask

    task automatic t_mid_value();
        write_delay(20'd100);
        pulse_work_and_measure(100, "R3");
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_default();
        t_write_keep();
        t_restart();
        t_zero();
        t_standby();
        t_mid_value();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule